// File: doc/BRIEF.md
# Bank-switched RAM card controller

This block is the control logic of a 16 KB RAM expansion card that lies over the top 12 KB of a 16-bit processor address space ($D000-$FFFF). Sixteen soft-switch locations at $C080-$C08F set it up. The low two bits of a switch address pick where reads come from and whether RAM writes are requested. Bit 3 picks which of two 4 KB banks appears at $D000-$DFFF.

Writing to RAM must be armed deliberately. Two successive reads of an odd switch arm it. A write cycle to an odd switch while only half armed cancels the arming, and so does any access to an even switch. The controller drives RAM read and write strobes, selects for the card's own ROM ($F800-$FFFF) and the mainboard ROM ($D000-$F7FF), and forms a 14-bit address into an external 16 KB SRAM.

Every valid bus cycle counts as exactly one access. Switch accesses take effect at the clock edge that ends the cycle. The strobes and the SRAM address are combinational from the current address and the registered state.

Top module: `lcard_ctrl`

## Requirements
- R1: Only valid cycles whose address lies in $C080-$C08F change the card state. Both reads and writes there take effect. Other addresses leave the state unchanged.
- R2: A switch access with address bit 3 = 0 selects the second 4 KB bank for $D000-$DFFF. Bit 3 = 1 selects the first bank.
- R3: Switch actions (address bits [1:0]) 0 and 3 select RAM as the read source. Actions 1 and 2 select ROM.
- R4: Any access to action 0 or 2, read or write, sets the write state to disabled.
- R5: Each read of action 1 or 3 moves the write state one step, from disabled to half-enabled to enabled, and it stays at enabled. RAM writes are enabled only in the enabled state, so one odd read is not enough and two are.
- R6: A write cycle to action 1 or 3 never advances the write state. It turns half-enabled back into disabled and leaves enabled or disabled as they are.
- R7: After reset the card reads from ROM, has RAM writes enabled, and selects the second bank.
- R8: ram_rd_en is 1 only for valid reads in $D000-$FFFF while RAM is the read source.
- R9: ram_wr_en is 1 only for valid writes in $D000-$FFFF while the write state is enabled. Neither ROM select is ever 1 on a write.
- R10: While ROM is the read source, valid reads of $F800-$FFFF raise card_rom_sel and valid reads of $D000-$F7FF raise main_rom_sel. At most one of the two is 1.
- R11: For a valid access in $E000-$FFFF, sram_addr = $2000 + addr[12:0]. For $D000-$DFFF it is addr[11:0] with the first bank and $1000 + addr[11:0] with the second bank. It is 0 otherwise.
- R12: A cycle with bus_valid low has no effect on the state, even at a switch address. All its strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus cycle valid; one access per cycle |
| bus_addr | input | 16 | Processor address |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| ram_rd_en | output | 1 | SRAM read strobe |
| ram_wr_en | output | 1 | SRAM write strobe |
| card_rom_sel | output | 1 | Card ROM select ($F800-$FFFF) |
| main_rom_sel | output | 1 | Mainboard ROM select ($D000-$F7FF) |
| sram_addr | output | 14 | Address into the 16 KB SRAM |

## Verification
The bench goes after the arming corner cases. A single odd read must not enable writes. A design that counted one access twice, or left out the half-enabled step, would write RAM after that one read. An odd read followed by an odd write and then another odd read must still leave writes disabled. A design that let the write leave the half-enabled state alone would arm on that next read. An even read after arming must block writes, and a write to an odd switch must not disarm a fully enabled card. Bank separation is checked through sram_addr: if the bank polarity were flipped, or the common region were overlaid on a bank, data from $D000-$DFFF in one bank would land on top of the other bank or of the $E000 region.

// File: rtl/lcard_pkg.sv
package lcard_pkg;

    typedef enum logic [1:0] {
        WS_OFF  = 2'd0,
        WS_HALF = 2'd1,
        WS_ON   = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        ACT_RAM_RO = 2'd0,
        ACT_ROM_WR = 2'd1,
        ACT_ROM_RO = 2'd2,
        ACT_RAM_WR = 2'd3
    } sw_act_e;

    typedef struct packed {
        logic      rd_ram;
        wr_state_e wr;
        logic      bank2;
    } card_state_t;

    localparam card_state_t CARD_RESET = '{rd_ram: 1'b0, wr: WS_ON, bank2: 1'b1};

    function automatic wr_state_e wr_advance(input wr_state_e cur);
        case (cur)
            WS_OFF:  return WS_HALF;
            WS_HALF: return WS_ON;
            WS_ON:   return WS_ON;
            default: return WS_OFF;
        endcase
    endfunction

endpackage

// File: rtl/lcard_swdec.sv
module lcard_swdec
    import lcard_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] SW_BASE = 16'hC080
) (
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              sw_hit,
    output sw_act_e           sw_act,
    output logic              sw_bank2
);
    localparam int TAG_LO = 4;

    always_comb begin
        sw_hit   = bus_valid && (bus_addr[ADDR_W-1:TAG_LO] == SW_BASE[ADDR_W-1:TAG_LO]);
        sw_act   = sw_act_e'(bus_addr[1:0]);
        sw_bank2 = ~bus_addr[3];
    end
endmodule

// File: rtl/lcard_state.sv
module lcard_state
    import lcard_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_hit,
    input  sw_act_e     sw_act,
    input  logic        sw_bank2,
    input  logic        bus_rd,
    output card_state_t st_q
);
    card_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (sw_hit) begin
            st_d.bank2 = sw_bank2;
            case (sw_act)
                ACT_RAM_RO: begin
                    st_d.rd_ram = 1'b1;
                    st_d.wr     = WS_OFF;
                end
                ACT_ROM_RO: begin
                    st_d.rd_ram = 1'b0;
                    st_d.wr     = WS_OFF;
                end
                default: begin
                    st_d.rd_ram = (sw_act == ACT_RAM_WR);
                    if (bus_rd) begin
                        st_d.wr = wr_advance(st_q.wr);
                    end else if (st_q.wr == WS_HALF) begin
                        st_d.wr = WS_OFF;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= CARD_RESET;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/lcard_map.sv
module lcard_map
    import lcard_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BANK_AW = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE    = 16'hD000,
    parameter logic [ADDR_W-1:0] COMMON_BASE = 16'hE000,
    parameter logic [ADDR_W-1:0] CROM_BASE   = 16'hF800
) (
    input  logic                 bus_valid,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  card_state_t          st,
    output logic                 ram_rd_en,
    output logic                 ram_wr_en,
    output logic                 card_rom_sel,
    output logic                 main_rom_sel,
    output logic [BANK_AW+1:0]   sram_addr
);
    localparam int SRAM_AW   = BANK_AW + 2;
    localparam int COMMON_AW = BANK_AW + 1;

    logic in_win, in_common, in_crom, rd_cyc, wr_cyc;

    always_comb begin
        in_win    = bus_valid && (bus_addr >= WIN_BASE);
        in_common = bus_addr >= COMMON_BASE;
        in_crom   = bus_addr >= CROM_BASE;
        rd_cyc    = in_win && bus_rd;
        wr_cyc    = in_win && !bus_rd;

        ram_rd_en    = rd_cyc && st.rd_ram;
        ram_wr_en    = wr_cyc && (st.wr == WS_ON);
        card_rom_sel = rd_cyc && !st.rd_ram && in_crom;
        main_rom_sel = rd_cyc && !st.rd_ram && !in_crom;

        sram_addr = '0;
        if (in_win) begin
            if (in_common) begin
                sram_addr = {1'b1, bus_addr[COMMON_AW-1:0]};
            end else begin
                sram_addr = {1'b0, st.bank2, bus_addr[BANK_AW-1:0]};
            end
        end
    end

    initial begin
        if (SRAM_AW != COMMON_AW + 1) $display("lcard_map: inconsistent widths");
    end
endmodule

// File: rtl/lcard_ctrl.sv
module lcard_ctrl
    import lcard_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BANK_AW = 12,
    parameter logic [ADDR_W-1:0] SW_BASE     = 16'hC080,
    parameter logic [ADDR_W-1:0] WIN_BASE    = 16'hD000,
    parameter logic [ADDR_W-1:0] COMMON_BASE = 16'hE000,
    parameter logic [ADDR_W-1:0] CROM_BASE   = 16'hF800
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_rd,
    output logic               ram_rd_en,
    output logic               ram_wr_en,
    output logic               card_rom_sel,
    output logic               main_rom_sel,
    output logic [BANK_AW+1:0] sram_addr
);
    logic        sw_hit;
    sw_act_e     sw_act;
    logic        sw_bank2;
    card_state_t st_q;
    logic        st_rd_ram, st_wr_on, st_bank2;

    lcard_swdec #(.ADDR_W(ADDR_W), .SW_BASE(SW_BASE)) u_dec (
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .sw_hit    (sw_hit),
        .sw_act    (sw_act),
        .sw_bank2  (sw_bank2)
    );

    lcard_state u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_hit   (sw_hit),
        .sw_act   (sw_act),
        .sw_bank2 (sw_bank2),
        .bus_rd   (bus_rd),
        .st_q     (st_q)
    );

    lcard_map #(
        .ADDR_W(ADDR_W), .BANK_AW(BANK_AW), .WIN_BASE(WIN_BASE),
        .COMMON_BASE(COMMON_BASE), .CROM_BASE(CROM_BASE)
    ) u_map (
        .bus_valid    (bus_valid),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .st           (st_q),
        .ram_rd_en    (ram_rd_en),
        .ram_wr_en    (ram_wr_en),
        .card_rom_sel (card_rom_sel),
        .main_rom_sel (main_rom_sel),
        .sram_addr    (sram_addr)
    );

    assign st_rd_ram = st_q.rd_ram;
    assign st_wr_on  = (st_q.wr == WS_ON);
    assign st_bank2  = st_q.bank2;
endmodule

// File: rtl/lcard_ctrl_chk.sv
module lcard_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] SW_BASE = 16'hC080
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              ram_rd_en,
    input logic              ram_wr_en,
    input logic              card_rom_sel,
    input logic              main_rom_sel,
    input logic              rd_ram,
    input logic              wr_on,
    input logic              bank2
);
    logic hit;
    assign hit = bus_valid && (bus_addr[ADDR_W-1:4] == SW_BASE[ADDR_W-1:4]);

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(rd_ram) && $stable(wr_on) && $stable(bank2));

    p_bank_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (bank2 == !$past(bus_addr[3])));

    p_read_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (rd_ram == ($past(bus_addr[0]) == $past(bus_addr[1]))));

    p_even_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !bus_addr[0]) |=> !wr_on);

    p_wr_no_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !bus_rd && !wr_on) |=> !wr_on);

    p_rd_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en |-> (rd_ram && bus_rd && bus_valid));

    p_wr_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_en |-> (wr_on && !bus_rd && !card_rom_sel && !main_rom_sel));

    p_rom_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (card_rom_sel || main_rom_sel) |-> (!rd_ram && bus_rd && !(card_rom_sel && main_rom_sel)));
endmodule

bind lcard_ctrl lcard_ctrl_chk #(.ADDR_W(ADDR_W), .SW_BASE(SW_BASE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid    (bus_valid),
    .bus_addr     (bus_addr),
    .bus_rd       (bus_rd),
    .ram_rd_en    (ram_rd_en),
    .ram_wr_en    (ram_wr_en),
    .card_rom_sel (card_rom_sel),
    .main_rom_sel (main_rom_sel),
    .rd_ram       (st_rd_ram),
    .wr_on        (st_wr_on),
    .bank2        (st_bank2)
);

// File: tb/sim_lcard_ctrl.sv
`timescale 1ns/1ps
module sim_lcard_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b1;
    logic        ram_rd_en, ram_wr_en, card_rom_sel, main_rom_sel;
    logic [13:0] sram_addr;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // reference model: read source, write state (0 off,1 half,2 on), bank2
    bit m_rd;
    int m_ws;
    bit m_b2;

    // last sampled outputs
    bit l_rd, l_wr, l_card, l_main;
    int l_sa;

    always #2.5 clk = ~clk;

    lcard_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en),
        .card_rom_sel(card_rom_sel), .main_rom_sel(main_rom_sel), .sram_addr(sram_addr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_sa(input bit v, input logic [15:0] a);
        if (!v || a < 16'hD000) return 0;
        if (a >= 16'hE000) return 32'h2000 + int'(a[12:0]);
        return (m_b2 ? 32'h1000 : 0) + int'(a[11:0]);
    endfunction

    task automatic model_update(input bit v, input logic [15:0] a, input bit r);
        if (v && a[15:4] == 12'hC08) begin
            m_b2 = !a[3];
            case (a[1:0])
                2'd0: begin m_rd = 1; m_ws = 0; end
                2'd2: begin m_rd = 0; m_ws = 0; end
                default: begin
                    m_rd = (a[1:0] == 2'd3);
                    if (r) m_ws = (m_ws >= 1) ? 2 : 1;
                    else if (m_ws == 1) m_ws = 0;
                end
            endcase
        end
    endtask

    task automatic step(input bit v, input logic [15:0] a, input bit r);
        bit win;
        @(negedge clk);
        bus_valid = v; bus_addr = a; bus_rd = r;
        #1;
        win = v && a >= 16'hD000;
        l_rd = ram_rd_en; l_wr = ram_wr_en; l_card = card_rom_sel;
        l_main = main_rom_sel; l_sa = int'(sram_addr);
        chk("R8 ram_rd_en", l_rd, win && r && m_rd);
        chk("R9 ram_wr_en", l_wr, win && !r && m_ws == 2);
        chk("R10 card_rom_sel", l_card, win && r && !m_rd && a >= 16'hF800);
        chk("R10 main_rom_sel", l_main, win && r && !m_rd && a < 16'hF800);
        chk("R11 sram_addr", l_sa, exp_sa(v, a));
        @(posedge clk);
        model_update(v, a, r);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_rd = 0; m_ws = 2; m_b2 = 1;

        // R7 reset state
        step(1, 16'hF900, 1); chk("R7 card ROM after reset", l_card, 1);
        step(1, 16'hD010, 0); chk("R7 write on after reset", l_wr, 1);
        chk("R7 second bank after reset", l_sa, 32'h1010);

        // R5 single odd read does not enable
        step(1, 16'hC082, 1);
        step(1, 16'hC081, 1);
        step(1, 16'hD020, 0); chk("R5 one odd read", l_wr, 0);
        step(1, 16'hC081, 1);
        step(1, 16'hD020, 0); chk("R5 two odd reads", l_wr, 1);
        step(1, 16'hC081, 1);
        step(1, 16'hD020, 0); chk("R5 saturates", l_wr, 1);

        // R6 write to odd keeps enabled
        step(1, 16'hC081, 0);
        step(1, 16'hD030, 0); chk("R6 odd write keeps on", l_wr, 1);

        // R4 even read after arming
        step(1, 16'hC080, 1);
        step(1, 16'hD040, 0); chk("R4 even read disarms", l_wr, 0);
        step(1, 16'hD040, 1); chk("R3 action0 RAM read", l_rd, 1);

        // R6 odd read then write cancels half arming
        step(1, 16'hC083, 1);
        step(1, 16'hC083, 0);
        step(1, 16'hC083, 1);
        step(1, 16'hE000, 0); chk("R6 write cancels half", l_wr, 0);
        step(1, 16'hC083, 1);
        step(1, 16'hE000, 0); chk("R6 rearm after two reads", l_wr, 1);

        // R4 even write disarms
        step(1, 16'hC08A, 0);
        step(1, 16'hE004, 0); chk("R4 even write disarms", l_wr, 0);
        step(1, 16'hF000, 1); chk("R3 action2 main ROM", l_main, 1);

        // R2 bank separation
        step(1, 16'hC08B, 1);
        step(1, 16'hD123, 1); chk("R2 first bank", l_sa, 32'h0123);
        step(1, 16'hC083, 1);
        step(1, 16'hD123, 1); chk("R2 second bank", l_sa, 32'h1123);
        step(1, 16'hE123, 1); chk("R11 common region", l_sa, 32'h2123);

        // R12 invalid cycle at switch address does nothing
        step(0, 16'hC08A, 1);
        step(1, 16'hD123, 1); chk("R12 invalid ignored", l_sa, 32'h1123);
        chk("R12 read src kept", l_rd, 1);

        // R1 nearby non-switch addresses do nothing
        step(1, 16'hC090, 1);
        step(1, 16'hC07A, 0);
        step(1, 16'hD200, 1); chk("R1 outside range", l_rd, 1);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int k;
            logic [15:0] a;
            k = $urandom_range(0, 9);
            if (k < 4) a = 16'hC080 | 16'($urandom_range(0, 15));
            else if (k < 8) a = 16'hD000 + 16'($urandom_range(0, 16'h2FFF));
            else a = 16'($urandom);
            step($urandom_range(0, 7) != 0, a, $urandom_range(0, 3) != 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule